// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a data cache that sits between a processor load/store port and a word-wide memory port. It holds 128 lines of 32 bytes each and is addressed with 32-bit byte addresses. Every address maps to exactly one line. The line number comes from the middle address bits, and the upper bits are kept as a tag to tell apart the many addresses that share that line.

The processor issues one word read or write at a time. It holds the request until `cpu_ready` pulses. A hit completes on the cycle after the request is accepted and creates no memory traffic. A write hit only updates the cached copy and flags the line as modified.

On a miss the controller first checks the single line the address maps to. If that line is valid and modified, its eight words go out to memory as a burst. The eight words of the requested line are then fetched, and the request is retried against the refilled line. Write misses allocate: the line is refilled first and the write is then merged into it.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address is a miss. While reset is released and idle, `cpu_ready` and `mem_req` are low.
- R2: Address fields are split as follows:
  - bits 1..0 are ignored;
  - bits 4..2 choose the word in the line;
  - bits 11..5 choose the line;
  - bits 31..12 are the tag.
  Two addresses that differ only in bits 31..12 compete for the same line.
- R3: An access hits when the chosen line is valid and its stored tag equals address bits 31..12. A hit raises `cpu_ready` on the cycle after acceptance, with no memory request.
- R4: A read returns the value most recently written to that word address, or the memory's content if the word was never written.
- R5: A write hit changes only the cached word and marks the line modified. Memory is not written until that line is evicted.
- R6: A miss fetches the whole line as eight memory reads. The word addresses increase by 4, starting at the line-aligned base (bits 4..0 zero). The request then completes.
- R7: When the line chosen by a miss is valid and modified, it is written back first. This is eight memory writes to the addresses of its stored tag, in increasing word order, issued before the refill reads.
- R8: A write miss refills the line, merges the write word and leaves the line modified.
- R9: `cpu_ready` is low from acceptance until the request completes, and it is high for a single cycle. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R10: After random traffic, evicting every line leaves the memory image equal to a reference model of all writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Refill word, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |

## Verification
The assertions assume the following about the environment:
- `mem_ack` is raised only while `mem_req` is high, and only for one cycle per word;
- the processor keeps its request fields stable until it sees `cpu_ready`.

The bench's memory responder acknowledges at a random delay of zero to two cycles and always drops `mem_ack` for at least one cycle between words. The processor driver changes its inputs only at the falling edge after a completion. Random traffic is confined to four tags over eight lines so that conflicting tags keep forcing dirty evictions.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_LINES  = 128;
    localparam int DEF_WORDS  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
`timescale 1ns/1ps
module dmc_tag_store #(
    parameter int LINES = dmc_pkg::DEF_LINES,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q, valid_d;
    logic [LINES-1:0] dirty_q, dirty_d;
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = 1'b0;
        end
        if (mark_dirty) begin
            dirty_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

    // R5
    mark_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |-> valid_q[idx]);

    // R8
    fill_then_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_dirty && !fill_en) |=> dirty_q[$past(idx)]);
endmodule

// File: rtl/dmc_data_store.sv
`timescale 1ns/1ps
module dmc_data_store #(
    parameter int LINES  = dmc_pkg::DEF_LINES,
    parameter int WORDS  = dmc_pkg::DEF_WORDS,
    parameter int DATA_W = dmc_pkg::DEF_DATA_W,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int DEPTH  = LINES * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{idx, wr_sel}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{idx, rd_sel}];
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int IDX_W  = 7,
    parameter int WSEL_W = 3,
    parameter int TAG_W  = 20,
    localparam int BOFF_W = ADDR_W - TAG_W - IDX_W - WSEL_W,
    localparam int WA_W   = ADDR_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    output logic [IDX_W-1:0]  idx,
    output logic              fill_en,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              mark_dirty,
    output logic              dwr_en,
    output logic [WSEL_W-1:0] dwr_sel,
    output logic [DATA_W-1:0] dwr_data,
    output logic [WSEL_W-1:0] drd_sel
);
    typedef struct packed {
        dmc_state_e        state;
        logic [WSEL_W-1:0] cnt;
        logic [WA_W-1:0]   wa;
        logic              we;
        logic [DATA_W-1:0] wd;
    } ctrl_t;

    ctrl_t q, d;

    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_word;
    logic              hit;
    logic              last_word;

    assign req_tag   = q.wa[WA_W-1 -: TAG_W];
    assign idx       = q.wa[WSEL_W +: IDX_W];
    assign req_word  = q.wa[WSEL_W-1:0];
    assign hit       = line_valid && (line_tag == req_tag);
    assign last_word = (q.cnt == {WSEL_W{1'b1}});
    assign fill_tag  = req_tag;

    always_comb begin
        d          = q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        dwr_en     = 1'b0;
        dwr_sel    = req_word;
        dwr_data   = q.wd;
        drd_sel    = req_word;
        unique case (q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.wa    = cpu_addr[ADDR_W-1:BOFF_W];
                    d.we    = cpu_we;
                    d.wd    = cpu_wdata;
                    d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                d.cnt = '0;
                if (hit) begin
                    cpu_ready = 1'b1;
                    if (q.we) begin
                        dwr_en     = 1'b1;
                        mark_dirty = 1'b1;
                    end
                    d.state = ST_IDLE;
                end else if (line_valid && line_dirty) begin
                    d.state = ST_EVICT;
                end else begin
                    d.state = ST_FILL;
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line_tag, idx, q.cnt, {BOFF_W{1'b0}}};
                drd_sel  = q.cnt;
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (last_word) begin
                        d.state = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, idx, q.cnt, {BOFF_W{1'b0}}};
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_sel  = q.cnt;
                    dwr_data = mem_rdata;
                    d.cnt    = q.cnt + 1'b1;
                    if (last_word) begin
                        fill_en = 1'b1;
                        d.state = ST_LOOKUP;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, wa: '0, we: 1'b0, wd: '0};
        end else begin
            q <= d;
        end
    end

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R1
    ready_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[BOFF_W +: WSEL_W] != {WSEL_W{1'b1}}))
        |=> (mem_req && (mem_addr[BOFF_W +: WSEL_W] ==
             WSEL_W'($past(mem_addr[BOFF_W +: WSEL_W]) + 1'b1))));

    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && (mem_addr[BOFF_W +: WSEL_W] == {WSEL_W{1'b1}}))
        |=> (mem_req && !mem_we && (mem_addr[BOFF_W +: WSEL_W] == '0)));
endmodule

// File: rtl/dm_wb_cache.sv
`timescale 1ns/1ps
module dm_wb_cache #(
    parameter int ADDR_W = dmc_pkg::DEF_ADDR_W,
    parameter int DATA_W = dmc_pkg::DEF_DATA_W,
    parameter int LINES  = dmc_pkg::DEF_LINES,
    parameter int WORDS  = dmc_pkg::DEF_WORDS,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BOFF_W = $clog2(DATA_W / 8),
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [IDX_W-1:0]  idx;
    logic              fill_en;
    logic [TAG_W-1:0]  fill_tag;
    logic              mark_dirty;
    logic              line_valid;
    logic              line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              dwr_en;
    logic [WSEL_W-1:0] dwr_sel;
    logic [DATA_W-1:0] dwr_data;
    logic [WSEL_W-1:0] drd_sel;
    logic [DATA_W-1:0] drd_data;

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W),
        .TAG_W  (TAG_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .idx        (idx),
        .fill_en    (fill_en),
        .fill_tag   (fill_tag),
        .mark_dirty (mark_dirty),
        .dwr_en     (dwr_en),
        .dwr_sel    (dwr_sel),
        .dwr_data   (dwr_data),
        .drd_sel    (drd_sel)
    );

    dmc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .fill_en    (fill_en),
        .fill_tag   (fill_tag),
        .mark_dirty (mark_dirty),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    dmc_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) i_data (
        .clk     (clk),
        .idx     (idx),
        .wr_en   (dwr_en),
        .wr_sel  (dwr_sel),
        .wr_data (dwr_data),
        .rd_sel  (drd_sel),
        .rd_data (drd_data)
    );

    assign cpu_rdata = drd_data;
    assign mem_wdata = drd_data;
endmodule

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    logic [31:0] bmem  [int unsigned];
    logic [31:0] ref_m [int unsigned];
    logic [32:0] ev_q [$];

    bit          sh_v [128];
    bit          sh_d [128];
    logic [19:0] sh_t [128];

    always #2.5 clk = ~clk;

    dm_wb_cache i_dm_wb_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] memv(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : init_val(a);
    endfunction

    function automatic logic [31:0] refv(input logic [31:0] a);
        return ref_m.exists(a) ? ref_m[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: one-cycle ack after 0..2 idle cycles, gap between words
    initial begin
        int wt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wt > 0) begin
                    wt--;
                end else begin
                    mem_ack = 1'b1;
                    ev_q.push_back({mem_we, mem_addr});
                    if (mem_we) bmem[mem_addr] = mem_wdata;
                    else        mem_rdata = memv(mem_addr);
                    wt = int'($urandom % 3);
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd);
        int          ix  = int'(a[11:5]);
        logic [19:0] tg  = a[31:12];
        logic [31:0] wa  = {a[31:2], 2'b00};
        bit          hit = sh_v[ix] && (sh_t[ix] == tg);
        bit          dwb = !hit && sh_v[ix] && sh_d[ix];
        logic [19:0] ot  = sh_t[ix];
        int          cyc = 0;
        int          nwb;
        @(negedge clk);
        ev_q.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 400);
        chk(cyc < 400, "R9 completion reached", cyc, 0);
        if (hit) begin
            chk(cyc == 1, "R3 hit completes one cycle after accept", cyc, 1);
            chk(ev_q.size() == 0, "R3 R5 hit makes no memory request", ev_q.size(), 0);
        end else begin
            nwb = dwb ? 8 : 0;
            chk(ev_q.size() == nwb + 8, "R6 R7 burst word count", ev_q.size(), nwb + 8);
            if (ev_q.size() == nwb + 8) begin
                for (int k = 0; k < nwb; k++) begin
                    chk(ev_q[k] == {1'b1, ot, ix[6:0], k[2:0], 2'b00},
                        "R7 write-back order and address", ev_q[k][31:0], {ot, ix[6:0], k[2:0], 2'b00});
                end
                for (int k = 0; k < 8; k++) begin
                    chk(ev_q[nwb+k] == {1'b0, tg, ix[6:0], k[2:0], 2'b00},
                        "R6 refill order and address", ev_q[nwb+k][31:0], {tg, ix[6:0], k[2:0], 2'b00});
                end
            end
            chk(cyc > 8, "R9 ready low through miss", cyc, 9);
        end
        if (!we) chk(cpu_rdata == refv(wa), "R4 read data", cpu_rdata, refv(wa));
        cpu_req = 1'b0;
        if (we) ref_m[wa] = wd;
        sh_v[ix] = 1'b1;
        sh_t[ix] = tg;
        if (!hit) sh_d[ix] = 1'b0;
        if (we) sh_d[ix] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] old;
        for (int i = 0; i < 128; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_t[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cpu_ready == 1'b0, "R1 ready low after reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R1 no memory request after reset", mem_req, 0);

        // R1 R6 cold read miss, then R3 hit on another word
        access(0, 32'h0000_1040, 0);
        access(0, 32'h0000_1054, 0);
        // R2 byte offset bits ignored: same word, hit
        access(0, 32'h0000_1057, 0);

        // R5 write hit: cache only
        old = memv(32'h0000_1048);
        access(1, 32'h0000_1048, 32'hDEAD_BEEF);
        chk(memv(32'h0000_1048) == old, "R5 memory untouched by write hit", memv(32'h0000_1048), old);
        access(0, 32'h0000_1048, 0);

        // R2 R7 conflicting tag on same index evicts dirty line
        access(0, 32'h0003_5040, 0);
        chk(memv(32'h0000_1048) == 32'hDEAD_BEEF, "R7 written-back word in memory",
            memv(32'h0000_1048), 32'hDEAD_BEEF);

        // R8 write miss allocates, then eviction shows merged word
        access(1, 32'h0000_2364, 32'h1234_5678);
        access(0, 32'h0000_2360, 0);
        access(0, 32'h0007_7360, 0);
        chk(memv(32'h0000_2364) == 32'h1234_5678, "R8 merged word written back",
            memv(32'h0000_2364), 32'h1234_5678);
        chk(memv(32'h0000_2360) == init_val(32'h0000_2360), "R8 other words kept",
            memv(32'h0000_2360), init_val(32'h0000_2360));

        // random traffic over conflicting tags
        for (int n = 0; n < 300; n++) begin
            a = {20'h00010 + 20'($urandom % 4), 7'($urandom % 8), 3'($urandom % 8), 2'($urandom % 4)};
            access(bit'($urandom % 2), a, $urandom);
        end

        // R10 evict every line, compare memory image
        for (int i = 0; i < 128; i++) begin
            access(0, {20'hFFFFF, i[6:0], 5'b0}, 0);
        end
        foreach (ref_m[k]) begin
            chk(memv(k) == ref_m[k], "R10 final memory image", memv(k), ref_m[k]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule